// File: doc/BRIEF.md
# Braid Distribution Unit

This block sits between an in-order decode stage and a set of braid execution units. It takes up to two decoded instructions per cycle and cuts the stream into braids. A braid is a compiler-formed group of instructions that always arrive back to back. A group begins at an instruction whose start flag is set and runs until the next flagged instruction. Each whole group is steered into the instruction queue of one execution unit that is not holding another group. When no unit is free, or when the chosen queue lacks room, the block holds the front end back by dropping its ready signal.

The block keeps an occupancy count for each unit queue. Each unit returns a per-slot issue (pop) indication and a one-cycle done pulse, and the done pulse hands that unit back to the free pool. A mode input forces every instruction into one fixed unit, whatever the start flags and busy state. Because that unit's queue is in order, the machine then executes strictly in order. Slot 1 may only be offered together with slot 0, and both offered slots are accepted or refused together.

Top module: `braid_dist`

## Requirements
- R1: A slot whose start flag is 1 opens a new braid, and so does any instruction arriving while no braid is open. A slot with start flag 0 goes to the unit holding the currently open braid, and that assignment holds until the next start flag.
- R2: A new braid goes to the lowest-numbered free unit. If both slots start braids in one cycle, slot 1 takes the lowest free unit other than the one slot 0 took.
- R3: A start flag on slot 1 only redirects slot 1: slot 0 of the same cycle still follows the braid that was open before.
- R4: A unit that has been given a braid stays busy until its done pulse. A done pulse is ignored for the unit that holds the currently open braid.
- R5: When a start-flagged slot finds no free unit outside exception mode, inReady is 0 and nothing is enqueued.
- R6: Each unit queue holds QUEUE_DEPTH entries. inReady is 0 when a target queue cannot take every slot sent to it this cycle. Two slots to one unit need two free entries. Pops in the same cycle are not counted as space.
- R7: Each set bit of unitPop frees one queue entry, taking effect from the next cycle.
- R8: While excMode is 1, every accepted instruction goes to unit EXC_UNIT, regardless of start flags and busy state. Only that queue's space can stall it.
- R9: enqMask bit 2*u+s is 1 exactly when slot s is written into unit u's queue this cycle. enqData is inData, slot s in bits [s*DATA_W +: DATA_W]. enqMask is 0 whenever the offer is not accepted.
- R10: After reset every unit is free, no braid is open and every queue is empty. inReady is 1 whenever slot 0 is not offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 2 | Per-slot offer; bit 1 only with bit 0 |
| inStart | input | 2 | Per-slot braid start flag |
| inData | input | 2*DATA_W | Per-slot decoded instruction |
| excMode | input | 1 | Force all instructions to unit EXC_UNIT |
| unitPop | input | 2*NUM_UNITS | Bit 2*u+s: unit u issued one entry |
| unitDone | input | NUM_UNITS | One-cycle pulse: unit finished its braid, queue empty |
| inReady | output | 1 | Offer accepted this cycle (when inValid[0]) |
| enqMask | output | 2*NUM_UNITS | Bit 2*u+s: slot s enqueued into unit u |
| enqData | output | 2*DATA_W | Instruction data for the enqueue ports |

## Verification
The bench builds the block with four units, four-entry queues, 8-bit data and unit 2 as the exception target. The short queues let one braid fill a queue and push the offer into both space stalls within a few cycles. The small unit count means a handful of starts exhausts the free pool. Under that configuration the walk covers every slot-0/slot-1 start combination and reuse of freed units in lowest-index order. It also covers an ignored done pulse on the open unit and an exception-mode burst that overrides busy units and start flags until the target queue is full.

// File: rtl/braid_pkg.sv
package braid_pkg;

  // Strobes from control to datapath for the current cycle.
  typedef struct packed {
    logic fire;   // offer accepted, slot 0 written
    logic use1;   // slot 1 written as well
  } dist_strobe_t;

endpackage

// File: rtl/braid_pick.sv
// Lowest-index one-hot picker over an availability vector.
module braid_pick #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] avail,
  output logic             found,
  output logic [WIDTH-1:0] pickOh
);
  always_comb begin
    pickOh = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (avail[i]) begin
        pickOh = '0;
        pickOh[i] = 1'b1;
      end
    end
    found = |avail;
  end
endmodule

// File: rtl/braid_dist_dp.sv
module braid_dist_dp
  import braid_pkg::*;
#(
  parameter int unsigned NUM_UNITS   = 8,
  parameter int unsigned QUEUE_DEPTH = 32,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dist_strobe_t             strobe,
  input  logic [NUM_UNITS-1:0]     tgt0Oh,
  input  logic [NUM_UNITS-1:0]     tgt1Oh,
  input  logic [2*NUM_UNITS-1:0]   unitPop,
  input  logic [2*DATA_W-1:0]      inData,
  output logic [2*NUM_UNITS-1:0]   enqMask,
  output logic [2*DATA_W-1:0]      enqData,
  output logic [NUM_UNITS-1:0]     hasOne,
  output logic [NUM_UNITS-1:0]     hasTwo
);
  localparam int unsigned CW = $clog2(QUEUE_DEPTH + 1);

  assign enqData = inData;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [CW-1:0] occ;
    logic [CW:0]   pushN, popN, occNext;
    logic          wr0, wr1;

    assign wr0 = strobe.fire & tgt0Oh[u];
    assign wr1 = strobe.fire & strobe.use1 & tgt1Oh[u];
    assign enqMask[2*u]   = wr0;
    assign enqMask[2*u+1] = wr1;

    always_comb begin
      pushN   = (CW+1)'(wr0) + (CW+1)'(wr1);
      popN    = (CW+1)'(unitPop[2*u]) + (CW+1)'(unitPop[2*u+1]);
      occNext = {1'b0, occ} + pushN - popN;
    end

    assign hasOne[u] = ({1'b0, occ} < (CW+1)'(QUEUE_DEPTH));
    assign hasTwo[u] = (({1'b0, occ} + (CW+1)'(2)) <= (CW+1)'(QUEUE_DEPTH));

    always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occNext[CW-1:0];
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occNext <= (CW+1)'(QUEUE_DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      popN <= {1'b0, occ});
  end
endmodule

// File: rtl/braid_dist_ctrl.sv
module braid_dist_ctrl
  import braid_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned EXC_UNIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           inValid,
  input  logic [1:0]           inStart,
  input  logic                 excMode,
  input  logic [NUM_UNITS-1:0] unitDone,
  input  logic [NUM_UNITS-1:0] hasOne,
  input  logic [NUM_UNITS-1:0] hasTwo,
  output logic                 inReady,
  output logic [NUM_UNITS-1:0] tgt0Oh,
  output logic [NUM_UNITS-1:0] tgt1Oh,
  output dist_strobe_t         strobe
);
  localparam logic [NUM_UNITS-1:0] EXC_OH = NUM_UNITS'(1) << EXC_UNIT;

  logic [NUM_UNITS-1:0] busy, curOh;
  logic                 curOpen;

  logic [NUM_UNITS-1:0] avail, pickA, pickB, newly, keepMask;
  logic                 foundA, foundB;
  logic                 new0, ok0, ok1, space, fire;

  assign avail = excMode ? '0 : ~busy;

  braid_pick #(.WIDTH(NUM_UNITS)) i_pickA (
    .avail (avail), .found (foundA), .pickOh (pickA));

  braid_pick #(.WIDTH(NUM_UNITS)) i_pickB (
    .avail (avail & ~pickA), .found (foundB), .pickOh (pickB));

  always_comb begin
    new0 = inStart[0] | ~curOpen;

    if (excMode) begin
      tgt0Oh = EXC_OH;
      tgt1Oh = EXC_OH;
      ok0    = 1'b1;
      ok1    = 1'b1;
    end else begin
      tgt0Oh = new0 ? pickA : curOh;
      ok0    = ~new0 | foundA;
      if (inStart[1]) begin
        tgt1Oh = new0 ? pickB : pickA;
        ok1    = ~inValid[1] | (new0 ? foundB : foundA);
      end else begin
        tgt1Oh = tgt0Oh;
        ok1    = 1'b1;
      end
    end

    if (inValid[1] && (tgt1Oh == tgt0Oh))
      space = |(tgt0Oh & hasTwo);
    else
      space = (|(tgt0Oh & hasOne)) & (~inValid[1] | (|(tgt1Oh & hasOne)));

    inReady = ~inValid[0] | (ok0 & ok1 & space);
    fire    = inValid[0] & ok0 & ok1 & space;

    newly = '0;
    if (fire) begin
      if (excMode) newly = EXC_OH;
      else begin
        if (new0) newly = newly | tgt0Oh;
        if (inValid[1] && inStart[1]) newly = newly | tgt1Oh;
      end
    end

    keepMask = curOpen ? curOh : '0;
  end

  assign strobe.fire = fire;
  assign strobe.use1 = inValid[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      curOh   <= '0;
      curOpen <= 1'b0;
    end else begin
      busy <= (busy & ~(unitDone & ~keepMask)) | newly;
      if (fire) begin
        curOh   <= inValid[1] ? tgt1Oh : tgt0Oh;
        curOpen <= 1'b1;
      end
    end
  end

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($onehot(tgt0Oh) && $onehot(tgt1Oh)));

  // R4
  busy_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && new0 && !excMode) |-> ((tgt0Oh & busy) == '0));

  // R5
  no_idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid[0] && inStart[0] && !excMode && (busy == '1)) |-> !inReady);

  // R8
  exc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && excMode) |=> (busy[EXC_UNIT] && curOpen && (curOh == EXC_OH)));

  // R4
  open_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curOpen && !fire && ((curOh & busy) != '0)) |=> ((curOh & busy) != '0));
endmodule

// File: rtl/braid_dist.sv
module braid_dist
  import braid_pkg::*;
#(
  parameter int unsigned NUM_UNITS   = 8,
  parameter int unsigned QUEUE_DEPTH = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned EXC_UNIT    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             inValid,
  input  logic [1:0]             inStart,
  input  logic [2*DATA_W-1:0]    inData,
  input  logic                   excMode,
  input  logic [2*NUM_UNITS-1:0] unitPop,
  input  logic [NUM_UNITS-1:0]   unitDone,
  output logic                   inReady,
  output logic [2*NUM_UNITS-1:0] enqMask,
  output logic [2*DATA_W-1:0]    enqData
);
  dist_strobe_t         strobe;
  logic [NUM_UNITS-1:0] tgt0Oh, tgt1Oh, hasOne, hasTwo;

  braid_dist_ctrl #(.NUM_UNITS(NUM_UNITS), .EXC_UNIT(EXC_UNIT)) i_ctrl (
    .clk (clk), .rst_n (rst_n), .inValid (inValid), .inStart (inStart),
    .excMode (excMode), .unitDone (unitDone), .hasOne (hasOne),
    .hasTwo (hasTwo), .inReady (inReady), .tgt0Oh (tgt0Oh),
    .tgt1Oh (tgt1Oh), .strobe (strobe));

  braid_dist_dp #(.NUM_UNITS(NUM_UNITS), .QUEUE_DEPTH(QUEUE_DEPTH),
                  .DATA_W(DATA_W)) i_dp (
    .clk (clk), .rst_n (rst_n), .strobe (strobe), .tgt0Oh (tgt0Oh),
    .tgt1Oh (tgt1Oh), .unitPop (unitPop), .inData (inData),
    .enqMask (enqMask), .enqData (enqData), .hasOne (hasOne),
    .hasTwo (hasTwo));
endmodule

// File: tb/test_braid_dist.sv
module test_braid_dist;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int D = 4;
  localparam int W = 8;
  localparam int EXC = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     inValid = '0, inStart = '0;
  logic [2*W-1:0] inData = '0;
  logic           excMode = 1'b0;
  logic [2*N-1:0] unitPop = '0;
  logic [N-1:0]   unitDone = '0;
  logic           inReady;
  logic [2*N-1:0] enqMask;
  logic [2*W-1:0] enqData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  braid_dist #(.NUM_UNITS(N), .QUEUE_DEPTH(D), .DATA_W(W), .EXC_UNIT(EXC))
    i_braid_dist (
      .clk (clk), .rst_n (rst_n), .inValid (inValid), .inStart (inStart),
      .inData (inData), .excMode (excMode), .unitPop (unitPop),
      .unitDone (unitDone), .inReady (inReady), .enqMask (enqMask),
      .enqData (enqData));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, sample, then cross the rising edge.
  task automatic step(input string req, input logic [1:0] v, input logic [1:0] s,
                      input logic exc, input logic [2*N-1:0] pop,
                      input logic [N-1:0] done, input logic expReady,
                      input logic [2*N-1:0] expMask);
    @(negedge clk);
    inValid  = v;
    inStart  = s;
    excMode  = exc;
    unitPop  = pop;
    unitDone = done;
    inData   = inData + 16'h0111;
    #1;
    check(req, "inReady", 32'(inReady), 32'(expReady));
    check(req, "enqMask", 32'(enqMask), 32'(expMask));
    check("R9", "enqData", 32'(enqData), 32'(inData));
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: idle after reset, ready with nothing offered
    step("R10", 2'b00, 2'b00, 0, '0, '0, 1'b1, 8'h00);
    // R1: start on slot 0, slot 1 follows -> unit 0 both slots
    step("R1", 2'b11, 2'b01, 0, '0, '0, 1'b1, 8'h03);
    // R3: slot 0 stays on unit 0, slot 1 start -> unit 1
    step("R3", 2'b11, 2'b10, 0, '0, '0, 1'b1, 8'h09);
    // R2: two starts -> units 2 and 3
    step("R2", 2'b11, 2'b11, 0, '0, '0, 1'b1, 8'h90);
    // R5: all busy, start stalls
    step("R5", 2'b01, 2'b01, 0, '0, '0, 1'b0, 8'h00);
    // R1: continuation into unit 3 (occupancy 1 -> 3)
    step("R1", 2'b11, 2'b00, 0, '0, '0, 1'b1, 8'hC0);
    // R6: two slots need two entries, only one left
    step("R6", 2'b11, 2'b00, 0, '0, '0, 1'b0, 8'h00);
    // R6: single slot fills unit 3
    step("R6", 2'b01, 2'b00, 0, '0, '0, 1'b1, 8'h40);
    // R6: full; pop from unit 3 this cycle is not yet space
    step("R6", 2'b01, 2'b00, 0, 8'h40, '0, 1'b0, 8'h00);
    // R7: popped entry now usable
    step("R7", 2'b01, 2'b00, 0, '0, '0, 1'b1, 8'h40);
    // R4: units 1 and 2 finish (drain + done)
    step("R4", 2'b00, 2'b00, 0, 8'h14, 4'b0110, 1'b1, 8'h00);
    // R2: two starts reuse lowest free units 1 and 2
    step("R2", 2'b11, 2'b11, 0, '0, '0, 1'b1, 8'h24);
    // R4: done on open unit 2 ignored; unit 0 drains two entries
    step("R4", 2'b00, 2'b00, 0, 8'h03, 4'b0100, 1'b1, 8'h00);
    step("R4", 2'b01, 2'b01, 0, '0, '0, 1'b0, 8'h00);
    // R4: unit 0 drains last entry and finishes
    step("R4", 2'b00, 2'b00, 0, 8'h01, 4'b0001, 1'b1, 8'h00);
    step("R4", 2'b01, 2'b01, 0, '0, '0, 1'b1, 8'h01);
    // R8: exception mode forces unit 2 despite busy and starts
    step("R8", 2'b11, 2'b11, 1, '0, '0, 1'b1, 8'h30);
    step("R8", 2'b11, 2'b00, 1, '0, '0, 1'b0, 8'h00);
    step("R8", 2'b01, 2'b01, 1, '0, '0, 1'b1, 8'h10);
    step("R8", 2'b01, 2'b01, 1, '0, '0, 1'b0, 8'h00);
    // R5: back in normal mode with every unit busy
    step("R5", 2'b01, 2'b01, 0, '0, '0, 1'b0, 8'h00);
    // R10: nothing offered, ready stays high
    step("R10", 2'b00, 2'b00, 0, '0, '0, 1'b1, 8'h00);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule